// File: doc/BRIEF.md
# SPI Master/Slave Controller with Fault Flags

This block is an 8-bit full-duplex serial engine for the SPI bus. It can act as the bus master, when it generates the serial clock from the system clock, or as a slave, when it follows a clock driven by another device. Software picks one of four clock polarity and phase pairings, a master clock divider, and where the slave select comes from: the select pin or a software-driven level.

The host side is a small register bus with four addresses: a data port, a control register, a read-only status register, and a slave-select configuration register. A byte written to the data port is shifted out MSB first while the incoming byte is shifted in. The incoming byte is then copied to a read buffer. A status flag marks each completed byte and can raise an interrupt.

Error conditions are reported rather than silently absorbed. A write to the data port during a transfer is dropped and flagged. A byte that completes before the previous one was taken is flagged, and the buffer keeps the older byte. The select line going active while the block is master is a bus fault: the block leaves master mode and stops driving the bus.

Top module: `spi_ctrl`

## Requirements
- R1: After synchronous reset, the control, status and select-configuration registers read 0, irq is low, and sck_oe, mosi_oe and miso_oe are low.
- R2: As master, a write to the data port starts a transfer. The byte goes out on mosi_o MSB first while miso_i is shifted in, and the received byte is readable at the data port after completion. This holds for all four polarity/phase settings.
- R3: While master is enabled and no transfer runs, sck_o rests at the CPOL level. With phase 0, data is sampled on the edge leaving the rest level; with phase 1, it is sampled on the edge returning to it.
- R4: In master mode, each SCK half period lasts 2^(rate+1) system clock cycles, where rate is control bits [6:4].
- R5: The done flag (status bit 0) sets when the eighth bit of a byte has been shifted. irq is high whenever the interrupt enable (control bit 7) is set and either the done flag or the fault flag is set.
- R6: A status read, followed immediately by a read or write of the data port as the next bus access, clears the done, write-collision and overrun flags. If any other access comes between them, the flags are not cleared.
- R7: A data-port write during a transfer sets the write-collision flag (status bit 1) and is discarded: the running byte and the next received byte are unaffected.
- R8: If a byte completes while the done flag is still set, the overrun flag (status bit 2) sets and the read buffer keeps the earlier byte.
- R9: If the internal select becomes active while enabled as master, the fault flag (status bit 3) sets, the enable and master bits are cleared, and sck_oe and mosi_oe drop. A status read followed by a control write clears the fault flag.
- R10: As slave, selected by a low ss_n_i, the block samples mosi_i on its external sck_i and returns the byte loaded while it was deselected on miso_o, MSB first. miso_oe is high only while the block is selected.
- R11: When software select is on (select-config bit 0), ss_n_i is ignored and the block is selected exactly when select-config bit 1 is 0.
- R12: Register map: address 0 is data (write loads the transmit byte, read returns the buffer); address 1 is control {ie[7], rate[6:4], cpha[3], cpol[2], master[1], enable[0]}; address 2 is status {fault[3], overrun[2], wcol[1], done[0]}; address 3 is select config {level[1], software[0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clearing side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data drive enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data drive enable |
| miso_i | input | 1 | Master data in |
| ss_n_i | input | 1 | Slave select pin, active low |

## Verification
The bench targets the flag corner cases. It writes the data port mid-transfer: a design that accepted that write would return the wrong byte. It lets two bytes complete without a read: a design that overwrote the buffer would return the newer byte. It puts a control read between the status read and the data read: a design that cleared flags on any later data access would lose the done flag. It pulls the select low under a master: a design without fault handling would keep driving SCK. In slave mode it also checks that an active select pin has no effect under software select, since a design that still used the pin would complete a byte it should have ignored.

// File: rtl/spi_ctrl_pkg.sv
// Shared constants and types for the SPI controller.
// Assumes the host register width is 8 bits.
package spi_ctrl_pkg;
    localparam int RATE_W = 3;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_CTRL = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_SSEL = 2'd3;

    // Control register layout, MSB first.
    typedef struct packed {
        logic              ie;
        logic [RATE_W-1:0] rate;
        logic              cpha;
        logic              cpol;
        logic              mstr;
        logic              en;
    } ctrl_t;
endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 2; each bit is treated independently.
module spi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift pin values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_baud.sv
// Master clock divider: pulses tick every 2^(rate+1) cycles while run is high.
// Assumes run is held for a whole transfer; the count restarts when run drops.
module spi_baud #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = (CNT_W'(2) << rate) - CNT_W'(1);
    assign tick = run && (cnt == lim);

    // Count cycles of the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spi_shift.sv
// Shift engine: MSB-first byte shifter driven by leading/trailing clock events.
// Phase 0 samples on leading and shifts on trailing; phase 1 changes output on
// leading and samples/shifts on trailing. load has priority over abort and edges.
module spi_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          abort,
    input  logic          lead,
    input  logic          trail,
    input  logic          cpha,
    input  logic          sin,
    output logic          obit,
    output logic          done,
    output logic [DW-1:0] rx_next
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] sr;
    logic [CW-1:0] cnt;
    logic          smp;
    logic          rxbit;

    assign rxbit   = cpha ? sin : smp;
    assign rx_next = {sr[DW-2:0], rxbit};
    assign done    = trail && (cnt == CW'(DW-1));

    // Load, sample and shift the serial byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            cnt  <= '0;
            smp  <= 1'b0;
            obit <= 1'b0;
        end else if (load) begin
            sr   <= ld_data;
            obit <= ld_data[DW-1];
            cnt  <= '0;
        end else if (abort) begin
            cnt  <= '0;
        end else begin
            if (lead) begin
                smp <= sin;
                if (cpha) obit <= sr[DW-1];
            end
            if (trail) begin
                sr  <= rx_next;
                cnt <= done ? '0 : cnt + 1'b1;
                if (!cpha) obit <= sr[DW-2];
            end
        end
    end

    // R2
    load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (obit == $past(ld_data[DW-1])));
endmodule

// File: rtl/spi_ctrl.sv
// SPI controller top: host registers, master clock generation, slave edge
// detection, and the transfer/collision/overrun/fault flags.
// Assumes DW == 8 (register layout) and slave-side pins are asynchronous.
module spi_ctrl
    import spi_ctrl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          sck_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          miso_i,
    input  logic          ss_n_i
);
    ctrl_t         ctrl;
    logic          sw_en, sw_lvl;
    logic          done_q, wcol_q, ovr_q, modf_q, arm_q;
    logic [DW-1:0] rbuf;
    logic          mbusy, sck_q, sck_prev;
    logic          sck_s, mosi_s, ss_s;
    logic          sel, is_m, is_s, busy, modf_evt;
    logic          data_wr, data_rd, data_acc, stat_rd, ctrl_wr, ssel_wr, any_acc;
    logic          clr_flags, clr_modf, hold;
    logic          load, start, tick;
    logic          m_lead, m_trail, s_edge, s_lead, s_trail, lead, trail;
    logic          abort, sin, obit, done_evt;
    logic [DW-1:0] rx_next;

    spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sck_i, mosi_i, ss_n_i}),
        .q({sck_s, mosi_s, ss_s})
    );

    // Mode and select decode.
    assign sel      = sw_en ? !sw_lvl : !ss_s;
    assign is_m     = ctrl.en && ctrl.mstr;
    assign is_s     = ctrl.en && !ctrl.mstr;
    assign modf_evt = is_m && sel;
    assign busy     = is_m ? mbusy : (is_s && sel);

    // Bus access decode.
    assign data_wr   = wr_en && (addr == ADR_DATA);
    assign data_rd   = rd_en && (addr == ADR_DATA);
    assign data_acc  = data_wr || data_rd;
    assign stat_rd   = rd_en && (addr == ADR_STAT);
    assign ctrl_wr   = wr_en && (addr == ADR_CTRL);
    assign ssel_wr   = wr_en && (addr == ADR_SSEL);
    assign any_acc   = wr_en || rd_en;
    assign clr_flags = arm_q && data_acc;
    assign clr_modf  = arm_q && ctrl_wr;
    assign hold      = done_q && !clr_flags;

    assign load  = data_wr && !busy;
    assign start = load && is_m && !modf_evt;

    spi_baud #(.RATE_W(RATE_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(mbusy), .rate(ctrl.rate), .tick(tick)
    );

    // Clock edge classification for both roles.
    assign m_lead  = tick && (sck_q == ctrl.cpol) && !modf_evt;
    assign m_trail = tick && (sck_q != ctrl.cpol) && !modf_evt;
    assign s_edge  = is_s && sel && (sck_s != sck_prev);
    assign s_lead  = s_edge && (sck_prev == ctrl.cpol);
    assign s_trail = s_edge && (sck_prev != ctrl.cpol);
    assign lead    = is_m ? m_lead  : s_lead;
    assign trail   = is_m ? m_trail : s_trail;
    assign abort   = modf_evt || (is_s && !sel);
    assign sin     = ctrl.mstr ? miso_i : mosi_s;

    spi_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_data(wdata), .abort(abort),
        .lead(lead), .trail(trail), .cpha(ctrl.cpha), .sin(sin),
        .obit(obit), .done(done_evt), .rx_next(rx_next)
    );

    // Master transfer-in-progress state.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mbusy <= 1'b0;
        else if (modf_evt || !is_m)  mbusy <= 1'b0;
        else if (start)              mbusy <= 1'b1;
        else if (done_evt)           mbusy <= 1'b0;
    end

    // Master SCK level: rests at CPOL, toggles on each divider tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      sck_q <= 1'b0;
        else if (!mbusy) sck_q <= ctrl.cpol;
        else if (tick)   sck_q <= ~sck_q;
    end

    // Previous synchronized slave clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Control register; a mode fault drops enable and master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (modf_evt) begin
            ctrl.en   <= 1'b0;
            ctrl.mstr <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(wdata[7:0]);
        end
    end

    // Software select configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en  <= 1'b0;
            sw_lvl <= 1'b0;
        end else if (ssel_wr) begin
            sw_en  <= wdata[0];
            sw_lvl <= wdata[1];
        end
    end

    // Arm flag: set by a status read, consumed by the next bus access.
    always_ff @(posedge clk) begin
        if (!rst_n)       arm_q <= 1'b0;
        else if (any_acc) arm_q <= stat_rd;
    end

    // Status flags and receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            wcol_q <= 1'b0;
            ovr_q  <= 1'b0;
            modf_q <= 1'b0;
            rbuf   <= '0;
        end else begin
            done_q <= hold || done_evt;
            ovr_q  <= (ovr_q && !clr_flags) || (done_evt && hold);
            wcol_q <= (wcol_q && !clr_flags) || (data_wr && busy);
            modf_q <= (modf_q && !clr_modf) || modf_evt;
            if (done_evt && !hold) rbuf <= rx_next;
        end
    end

    // Register read mux.
    always_comb begin
        unique case (addr)
            ADR_DATA: rdata = rbuf;
            ADR_CTRL: rdata = DW'(ctrl);
            ADR_STAT: rdata = DW'({modf_q, ovr_q, wcol_q, done_q});
            default:  rdata = DW'({sw_lvl, sw_en});
        endcase
    end

    assign irq     = ctrl.ie && (done_q || modf_q);
    assign sck_o   = sck_q;
    assign sck_oe  = is_m;
    assign mosi_o  = obit;
    assign mosi_oe = is_m;
    assign miso_o  = obit;
    assign miso_oe = is_s && sel;

    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mbusy && $past(!mbusy) && (ctrl.cpol == $past(ctrl.cpol))) |-> (sck_o == ctrl.cpol));
    // R9
    modf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        modf_evt |=> (!ctrl.en && !ctrl.mstr && modf_q && !sck_oe && !mosi_oe));
    // R8
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && done_q && !clr_flags) |=> (ovr_q && $stable(rbuf)));
    // R7
    wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> wcol_q);
    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !(done_q && !clr_flags)) |=> (done_q && (rbuf == $past(rx_next))));
endmodule

// File: tb/tb_spi_ctrl.sv
`timescale 1ns/1ps
module tb_spi_ctrl;
    localparam int H = 8;
    localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_SSEL = 2'd3;
    // {cpol, cpha, rate[2:0], inv, tx[7:0]}
    localparam logic [13:0] VEC [6] = '{
        {1'b0, 1'b0, 3'd0, 1'b0, 8'hA5},
        {1'b0, 1'b1, 3'd1, 1'b1, 8'h3C},
        {1'b1, 1'b0, 3'd0, 1'b1, 8'h81},
        {1'b1, 1'b1, 3'd2, 1'b0, 8'h5A},
        {1'b0, 1'b0, 3'd3, 1'b1, 8'hF0},
        {1'b1, 1'b1, 3'd0, 1'b0, 8'h01}
    };

    logic clk = 0, rst_n = 0;
    logic [1:0] addr = 0;
    logic wr_en = 0, rd_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
    logic sck_i = 0, mosi_i = 0, ss_n_i = 1, inv = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    assign miso_i = mosi_o ^ inv;

    spi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_done(input string tag);
        logic [7:0] s = 0;
        int n = 0;
        while (!s[0] && n < 2000) begin bus_rd(A_STAT, s); n++; end
        if (!s[0]) chk(tag, s, 8'h01);
    endtask

    task automatic slv_xfer(input logic cpol, input logic cpha, input logic [7:0] tx,
                            output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = tx[i]; repeat (H) @(negedge clk);
                rx[i] = miso_o; sck_i = ~cpol; repeat (H) @(negedge clk);
                sck_i = cpol;
            end else begin
                repeat (H) @(negedge clk);
                sck_i = ~cpol; mosi_i = tx[i]; repeat (H) @(negedge clk);
                rx[i] = miso_o; sck_i = cpol;
            end
        end
        repeat (H) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, rx;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        bus_rd(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
        bus_rd(A_STAT, d); chk("R1 status", d, 8'h00);
        bus_rd(A_SSEL, d); chk("R1 ssel", d, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 8'h00);

        // Vector table: R2 / R3 / R6 across the four clock modes
        for (int i = 0; i < 6; i++) begin
            logic [13:0] v;
            v = VEC[i];
            inv = v[8];
            bus_wr(A_CTRL, {1'b0, v[11:9], v[12], v[13], 2'b11});
            repeat (2) @(negedge clk);
            chk("R3 idle level", sck_o, v[13]);
            bus_wr(A_DATA, v[7:0]);
            wait_done("R5 done timeout");
            bus_rd(A_DATA, d); chk("R2 rx byte", d, v[7:0] ^ {8{v[8]}});
            bus_rd(A_STAT, d); chk("R6 cleared", d, 8'h00);
            chk("R3 idle after", sck_o, v[13]);
        end
        inv = 0;

        // R4 half-period length
        for (int r = 0; r < 4; r += 3) begin
            bus_wr(A_CTRL, {1'b0, 3'(r), 4'b0011});
            bus_wr(A_DATA, 8'h55);
            cnt = 0;
            while (sck_o !== 1'b1 && cnt < 500) begin @(negedge clk); cnt++; end
            cnt = 0;
            while (sck_o === 1'b1 && cnt < 500) begin cnt++; @(negedge clk); end
            chk("R4 half period", 8'(cnt), 8'(2 << r));
            wait_done("R4 done timeout");
            bus_rd(A_DATA, d);
        end

        // R5 interrupt
        bus_wr(A_CTRL, 8'h83);
        bus_wr(A_DATA, 8'h11);
        chk("R5 irq busy", irq, 0);
        wait_done("R5 done timeout");
        chk("R5 irq set", irq, 1);
        bus_rd(A_DATA, d);
        chk("R5 irq clear", irq, 0);

        // R6 intervening access keeps flags
        bus_wr(A_CTRL, 8'h03);
        bus_wr(A_DATA, 8'h6E);
        wait_done("R6 done timeout");
        bus_rd(A_CTRL, d);
        bus_rd(A_DATA, d); chk("R6 data", d, 8'h6E);
        bus_rd(A_STAT, d); chk("R6 not cleared", d, 8'h01);
        bus_rd(A_DATA, d);
        bus_rd(A_STAT, d); chk("R6 cleared", d, 8'h00);

        // R7 write collision
        bus_wr(A_DATA, 8'h96);
        bus_wr(A_DATA, 8'h0F);
        wait_done("R7 done timeout");
        bus_rd(A_STAT, d); chk("R7 wcol flag", d, 8'h03);
        bus_rd(A_DATA, d); chk("R7 write discarded", d, 8'h96);
        bus_rd(A_STAT, d); chk("R7 cleared", d, 8'h00);

        // R8 overrun
        bus_wr(A_DATA, 8'h44);
        repeat (60) @(negedge clk);
        bus_wr(A_DATA, 8'h77);
        repeat (60) @(negedge clk);
        bus_rd(A_STAT, d); chk("R8 ovr flag", d, 8'h05);
        bus_rd(A_DATA, d); chk("R8 old byte kept", d, 8'h44);
        bus_rd(A_STAT, d); chk("R8 cleared", d, 8'h00);

        // R9 master-mode fault
        bus_wr(A_CTRL, 8'h83);
        ss_n_i = 0;
        repeat (5) @(negedge clk);
        chk("R9 irq", irq, 1);
        chk("R9 drivers off", {sck_oe, mosi_oe}, 8'h00);
        bus_rd(A_CTRL, d); chk("R9 ctrl bits", d, 8'h80);
        bus_rd(A_STAT, d); chk("R9 fault flag", d, 8'h08);
        ss_n_i = 1;
        repeat (4) @(negedge clk);
        bus_wr(A_CTRL, 8'h00);
        bus_rd(A_STAT, d); chk("R9 fault cleared", d, 8'h00);

        // R10 slave, phase 0 then phase 1
        sck_i = 0;
        bus_wr(A_CTRL, 8'h01);
        bus_wr(A_DATA, 8'hA5);
        chk("R10 miso_oe idle", miso_oe, 0);
        ss_n_i = 0; repeat (4) @(negedge clk);
        chk("R10 miso_oe sel", miso_oe, 1);
        slv_xfer(0, 0, 8'h3C, rx);
        chk("R10 miso byte m0", rx, 8'hA5);
        ss_n_i = 1; repeat (4) @(negedge clk);
        bus_rd(A_STAT, d); chk("R10 done", d, 8'h01);
        bus_rd(A_DATA, d); chk("R10 rx byte m0", d, 8'h3C);
        sck_i = 1; repeat (4) @(negedge clk);
        bus_wr(A_CTRL, 8'h0D);
        bus_wr(A_DATA, 8'hC3);
        ss_n_i = 0; repeat (4) @(negedge clk);
        slv_xfer(1, 1, 8'h5A, rx);
        chk("R10 miso byte m3", rx, 8'hC3);
        ss_n_i = 1; repeat (4) @(negedge clk);
        bus_rd(A_STAT, d);
        bus_rd(A_DATA, d); chk("R10 rx byte m3", d, 8'h5A);

        // R11 software select overrides the pin
        sck_i = 0; repeat (4) @(negedge clk);
        bus_wr(A_SSEL, 8'h03);
        bus_wr(A_CTRL, 8'h01);
        ss_n_i = 0;
        bus_wr(A_DATA, 8'h99);
        repeat (4) @(negedge clk);
        chk("R11 pin ignored oe", miso_oe, 0);
        slv_xfer(0, 0, 8'h12, rx);
        bus_rd(A_STAT, d); chk("R11 pin ignored done", d, 8'h00);
        ss_n_i = 1;
        bus_wr(A_SSEL, 8'h01);
        repeat (4) @(negedge clk);
        chk("R11 sw select oe", miso_oe, 1);
        slv_xfer(0, 0, 8'h34, rx);
        chk("R11 miso byte", rx, 8'h99);
        bus_rd(A_STAT, d); chk("R11 done", d, 8'h01);
        bus_rd(A_DATA, d); chk("R11 rx byte", d, 8'h34);

        // R12 register map read-back
        bus_wr(A_SSEL, 8'h02);
        bus_rd(A_SSEL, d); chk("R12 ssel map", d, 8'h02);
        bus_wr(A_CTRL, 8'hDC);
        bus_rd(A_CTRL, d); chk("R12 ctrl map", d, 8'hDC);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule